// File: doc/BRIEF.md
# Peripheral-Synchronous CPU Clock Stretcher

This block paces a processor and its slow peripherals from one system clock. It issues single-cycle phase enables for the CPU and, separately, for the peripherals. Each system clock cycle is one fast CPU half-period. The peripheral enables come from a free-running divider with a symmetric period of `2*DIV_RATIO` system cycles. They never change rate, so peripherals only ever see the slow cadence. `DIV_RATIO` is a power of two from 2 to 16 and defaults to 8.

When the address decoder raises `periph_sel` at the start of a CPU phase-2, the CPU is not slowed at once. Its phase-2 is held, with no CPU enable, until the slow clock enters its own phase-2. From that aligned point the CPU phase-2 runs for one full slow half-period. The CPU phase-1 that follows coincides with the peripheral phase-1. After that the block returns to the fast rate, unless the access continues into the next bus cycle.

There is no data stream here: every pin is a plain control or status level or pulse. No valid/ready handshake applies.

Top module: `clk_stretch_sync`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cpu_p1_en` and `slow_p1_en` are 1 and `cpu_p2_en`, `slow_p2_en` and `stretch_active` are 0. The cycle after that shows `cpu_p2_en` at 1.
- R2: `slow_p1_en` pulses every `2*DIV_RATIO` cycles, starting with the first cycle after reset. `slow_p2_en` pulses exactly `DIV_RATIO` cycles after each `slow_p1_en`. Neither is affected by `periph_sel` or stretching.
- R3: When not stretching and not holding, `cpu_p1_en` and `cpu_p2_en` alternate on every cycle, so each CPU phase lasts one cycle.
- R4: `periph_sel` is looked at only in a fast-rate cycle with `cpu_p2_en` high, or in the last cycle of a stretched phase-2 (the cycle before `slow_p1_en`). In any other cycle it has no effect on any output.
- R5: After `periph_sel` is sampled high at a fast phase-2 start, no CPU enable is issued until the cycle in which `slow_p2_en` pulses. `stretch_active` rises in that cycle, and the CPU stays in phase-2. If the sample falls in the slow phase-2 half, the hold lasts through the whole next slow phase-1.
- R6: While `stretch_active` is 1, `cpu_p1_en` equals `slow_p1_en`, and `cpu_p2_en` is high only together with `slow_p2_en`. A stretched CPU phase-2 ends exactly at the next `slow_p1_en`.
- R7: If `periph_sel` is low in the last cycle of a stretched phase-2, `stretch_active` falls in the cycle that shows both `cpu_p1_en` and `slow_p1_en`. The next cycle shows `cpu_p2_en` (fast rate resumed).
- R8: If `periph_sel` is high in the last cycle of a stretched phase-2, `stretch_active` stays 1. The next CPU phase-1 then lasts `DIV_RATIO` cycles, and its phase-2 starts with `slow_p2_en`.
- R9: A sample taken in the cycle just before `slow_p2_en` gives the shortest hold: `stretch_active` rises in the very next cycle.
- R10: At most one CPU enable is high in any cycle, and `cpu_p1_en` and `cpu_p2_en` strictly alternate, so no phase is lost or shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one cycle is one fast CPU half-period |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_sel | input | 1 | Peripheral access flag from the address decoder |
| cpu_p1_en | output | 1 | Pulse marking the first cycle of a CPU phase-1 |
| cpu_p2_en | output | 1 | Pulse marking the first cycle of a CPU phase-2 |
| slow_p1_en | output | 1 | Pulse marking the start of peripheral phase-1 |
| slow_p2_en | output | 1 | Pulse marking the start of peripheral phase-2 |
| stretch_active | output | 1 | CPU is running at the peripheral rate |

## Verification
The bench aims at the alignment boundaries. One sample lands one cycle before the slow phase-2 start. A design that misses this case would hold for a full extra slow period. Another sample lands past the slow midpoint. A design that aligns to the wrong slow edge would start a CPU phase-2 together with a peripheral phase-1.

`periph_sel` is also pulsed in fast phase-1 cycles, during a hold and inside stretched cycles. A design that samples too often would stretch when it should not. A back-to-back access checks that the CPU phase-1 stays slow instead of collapsing to one cycle. A reset asserted in the middle of a stretch checks that the flag and the divider restart aligned.

// File: rtl/clkst_pkg.sv
package clkst_pkg;
  typedef enum logic {
    CPU_PH1 = 1'b0,
    CPU_PH2 = 1'b1
  } cpu_phase_e;
endpackage

// File: rtl/clkst_divider.sv
module clkst_divider #(
  parameter int unsigned DIV_RATIO = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic slow_p1_en,
  output logic slow_p2_en,
  output logic half_end,
  output logic full_end
);
  localparam int unsigned PERIOD = 2 * DIV_RATIO;
  localparam int unsigned CNT_W  = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] POS_MID      = CNT_W'(DIV_RATIO);
  localparam logic [CNT_W-1:0] POS_MID_LAST = CNT_W'(DIV_RATIO - 1);
  localparam logic [CNT_W-1:0] POS_LAST     = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  // Power-of-two period: natural wrap of the counter closes the cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(1);
  end

  assign slow_p1_en = (cnt_q == '0);
  assign slow_p2_en = (cnt_q == POS_MID);
  assign half_end   = (cnt_q == POS_MID_LAST);
  assign full_end   = (cnt_q == POS_LAST);
endmodule

// File: rtl/clkst_phase.sv
module clkst_phase
  import clkst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output cpu_phase_e phase_q,
  output logic       first_q,
  output logic       cpu_p1_en,
  output logic       cpu_p2_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= CPU_PH1;
      first_q <= 1'b1;
    end else begin
      if (adv) phase_q <= cpu_phase_e'(~phase_q);
      first_q <= adv;
    end
  end

  assign cpu_p1_en = first_q && (phase_q == CPU_PH1);
  assign cpu_p2_en = first_q && (phase_q == CPU_PH2);
endmodule

// File: rtl/clkst_ctl.sv
module clkst_ctl
  import clkst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       periph_sel,
  input  cpu_phase_e phase_q,
  input  logic       first_q,
  input  logic       half_end,
  input  logic       full_end,
  output logic       adv,
  output logic       stretch_q
);
  logic hold_q;
  logic enter;
  logic pending;
  logic hold_d;
  logic stretch_d;

  // Fresh request: a fast phase-2 start with the select high.
  assign enter   = (phase_q == CPU_PH2) && first_q && !stretch_q && !hold_q && periph_sel;
  assign pending = enter || hold_q;

  always_comb begin
    unique case (phase_q)
      CPU_PH1: adv = stretch_q ? half_end : 1'b1;
      CPU_PH2: adv = stretch_q ? full_end : !pending;
      default: adv = 1'b1;
    endcase
  end

  assign hold_d    = pending && !half_end;
  assign stretch_d = stretch_q ? !(full_end && !periph_sel) : (pending && half_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      stretch_q <= 1'b0;
    end else begin
      hold_q    <= hold_d;
      stretch_q <= stretch_d;
    end
  end
endmodule

// File: rtl/clk_stretch_sync.sv
module clk_stretch_sync
  import clkst_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic periph_sel,
  output logic cpu_p1_en,
  output logic cpu_p2_en,
  output logic slow_p1_en,
  output logic slow_p2_en,
  output logic stretch_active
);
  logic       half_end;
  logic       full_end;
  logic       adv;
  logic       first_q;
  cpu_phase_e phase_q;

  clkst_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_p1_en (slow_p1_en),
    .slow_p2_en (slow_p2_en),
    .half_end   (half_end),
    .full_end   (full_end)
  );

  clkst_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_sel (periph_sel),
    .phase_q    (phase_q),
    .first_q    (first_q),
    .half_end   (half_end),
    .full_end   (full_end),
    .adv        (adv),
    .stretch_q  (stretch_active)
  );

  clkst_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .phase_q   (phase_q),
    .first_q   (first_q),
    .cpu_p1_en (cpu_p1_en),
    .cpu_p2_en (cpu_p2_en)
  );
endmodule

// File: rtl/clkst_checker.sv
module clkst_checker #(
  parameter int unsigned DIV_RATIO = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cpu_p1_en,
  input logic cpu_p2_en,
  input logic slow_p1_en,
  input logic slow_p2_en,
  input logic stretch_active
);
  localparam int unsigned PERIOD = 2 * DIV_RATIO;

  int unsigned slot_q;
  logic        saw_p1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= 0;
      saw_p1_q <= 1'b0;
    end else begin
      slot_q <= (slot_q == PERIOD - 1) ? 0 : slot_q + 1;
      if (cpu_p1_en)      saw_p1_q <= 1'b1;
      else if (cpu_p2_en) saw_p1_q <= 1'b0;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> !stretch_active);

  a_r2_slow_cadence: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_p1_en == (slot_q == 0)) && (slow_p2_en == (slot_q == DIV_RATIO)));

  a_r5_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stretch_active) |-> slow_p2_en && !cpu_p1_en && !cpu_p2_en);

  a_r6_p1_locked: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_active |-> (cpu_p1_en == slow_p1_en));

  a_r6_p2_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch_active && cpu_p2_en) |-> slow_p2_en);

  a_r7_fall_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stretch_active) |-> cpu_p1_en && slow_p1_en);

  a_r10_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_p1_en, cpu_p2_en}));

  a_r10_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_p1_en |-> !saw_p1_q) and (cpu_p2_en |-> saw_p1_q));
endmodule

bind clk_stretch_sync clkst_checker #(.DIV_RATIO(DIV_RATIO)) u_clkst_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_p1_en      (cpu_p1_en),
  .cpu_p2_en      (cpu_p2_en),
  .slow_p1_en     (slow_p1_en),
  .slow_p2_en     (slow_p2_en),
  .stretch_active (stretch_active)
);

// File: tb/test_clk_stretch_sync.sv
module test_clk_stretch_sync;
  localparam int unsigned RATIO = 8;
  localparam int unsigned PER   = 2 * RATIO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic periph_sel = 1'b0;
  logic cpu_p1_en, cpu_p2_en, slow_p1_en, slow_p2_en, stretch_active;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         cyc;
    logic [4:0] vec;
    string      req;
  } exp_t;

  exp_t sb_q[$];

  clk_stretch_sync #(.DIV_RATIO(RATIO)) i_clk_stretch_sync (
    .clk            (clk),
    .rst_n          (rst_n),
    .periph_sel     (periph_sel),
    .cpu_p1_en      (cpu_p1_en),
    .cpu_p2_en      (cpu_p2_en),
    .slow_p1_en     (slow_p1_en),
    .slow_p2_en     (slow_p2_en),
    .stretch_active (stretch_active)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  function automatic bit in_hold(int k);
    return (k >= 34 && k <= 39) || (k >= 58 && k <= 71) || (k >= 162 && k <= 167);
  endfunction

  function automatic bit in_str(int k);
    return (k >= 40 && k <= 47) || (k >= 72 && k <= 95) ||
           (k >= 120 && k <= 127) || (k >= 168 && k <= 175);
  endfunction

  function automatic bit sel_for(int k);
    return k == 33 || k == 35 || k == 37 || k == 57 || (k >= 79 && k <= 94) ||
           k == 98 || k == 100 || k == 102 || k == 119 || k == 161;
  endfunction

  // Vector order: {cpu_p1_en, cpu_p2_en, slow_p1_en, slow_p2_en, stretch_active}
  function automatic logic [4:0] exp_for(int k);
    logic c1, c2, s1, s2, st;
    s1 = (k % PER == 0);
    s2 = (k % PER == RATIO);
    if (in_hold(k)) begin
      c1 = 1'b0; c2 = 1'b0; st = 1'b0;
    end else if (in_str(k)) begin
      c1 = (k == 80); c2 = (k == 88); st = 1'b1;
    end else begin
      c1 = (k % 2 == 0); c2 = (k % 2 == 1); st = 1'b0;
    end
    return {c1, c2, s1, s2, st};
  endfunction

  function automatic string tag_for(int k);
    if (k == 0) return "R1";
    if (k == 119 || k == 120) return "R9";
    if (k == 35 || k == 37) return "R4";
    if (in_hold(k)) return "R5";
    if (k >= 80 && k <= 95) return "R8";
    if (in_str(k)) return "R6";
    if (k == 48 || k == 49 || k == 96 || k == 97 || k == 128 || k == 129) return "R7";
    if (k >= 98 && k <= 103) return "R4";
    if (k >= 104 && k <= 118) return "R10";
    if (k % RATIO == 0) return "R2";
    return "R3";
  endfunction

  task automatic compare(string req, int k, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, k, act, exp);
    end
  endtask

  task automatic drive_push(int k);
    exp_t it;
    periph_sel = sel_for(k);
    it.cyc = k;
    it.vec = exp_for(k);
    it.req = tag_for(k);
    sb_q.push_back(it);
  endtask

  // Monitor: pops expected items and compares away from the active edge.
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
      exp_t it;
      it = sb_q.pop_front();
      compare(it.req, it.cyc,
              {cpu_p1_en, cpu_p2_en, slow_p1_en, slow_p2_en, stretch_active}, it.vec);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1", -1, {cpu_p1_en, cpu_p2_en, slow_p1_en, slow_p2_en, stretch_active}, 5'b10100);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    drive_push(0);
    for (int k = 1; k <= 172; k++) begin
      @(posedge clk);
      #2;
      drive_push(k);
    end
    // Reset in the middle of a stretched cycle (R1).
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    periph_sel = 1'b0;
    @(negedge clk);
    compare("R1", -2, {cpu_p1_en, cpu_p2_en, slow_p1_en, slow_p2_en, stretch_active}, 5'b10100);
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1", 0, {cpu_p1_en, cpu_p2_en, slow_p1_en, slow_p2_en, stretch_active}, 5'b10100);
    @(negedge clk);
    compare("R1", 1, {cpu_p1_en, cpu_p2_en, slow_p1_en, slow_p2_en, stretch_active}, 5'b01000);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule